// File: doc/BRIEF.md
# Reshapeable Ring Systolic Matrix Multiplier

This block is an output-stationary matrix multiplier built on a square grid of P×P processing elements. Its physical grid is cut into four contiguous quarters. These can run as the plain square, or they can be chained end to end through short links at the grid edge to form one long logical ring. A long-and-thin logical shape keeps nearly every element busy when one dimension of the product is small. Software picks the logical row count. The block derives the column count, checks that the pair is legal and rejects requests that are not.

After a start pulse, the block asks for one column vector of A and one row vector of B per cycle, for Mt cycles. It skews the operands across the array, sending them through a bypass stage at each quarter turn. Each element accumulates one entry of the product. A cycle counter raises the done flag when the counter reaches the execution time for the active shape and Mt. The product matrix then leaves the block one row per cycle.

Top module: `ring_systolic_array`

## Requirements
- R1: After reset the shape is square (Rl = Cl = P = 8). A shape write with value v, taken while idle, is legal in exactly three cases. When v = P the shape is square with Cl = P. When 1 ≤ v ≤ P/2 the shape is row-flattened with Cl = 4·(P − v). When v is a multiple of 4 and P/2 ≤ v/4 ≤ P − 1 the shape is column-flattened with Cl = P − v/4.
- R2: A write of an illegal value sets shape_err and leaves the active shape unchanged. A later legal write clears shape_err.
- R3: A shape write or a start pulse that arrives while a tile is running or results are being sent is ignored.
- R4: Counting from the clock edge that takes start, op_take is high for exactly Mt consecutive cycles, beginning after edge number Rl. Operands are captured only in those cycles.
- R5: done is high for a single cycle, right after edge number Texe following the start edge. Texe = 2·Rl + Cl + Mt − 1 + 4·min(Rl, Cl).
- R6: In square mode each result entry (i, j) equals the unsigned sum over k of A[i][k]·B[k][j]. This holds up to Mt = 63 with all operands at 255, without overflow.
- R7: In row-flattened mode the results are correct for every column, including the columns that sit past a quarter turn.
- R8: In column-flattened mode the results are correct for every row, including the rows that sit past a quarter turn.
- R9: In the Rl cycles after done, res_valid is high and res_row_idx counts 0 to Rl − 1. Result lanes c ≥ Cl read zero.
- R10: Lane r of a_in (bits r·8 upward) carries row r of the A column. Lane c of b_in carries column c of the B row. Lane c of res_row (bits c·22 upward) carries result column c. Lanes beyond the active Rl or Cl are ignored.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Shape write strobe |
| cfg_rows | input | RW (5) | Requested logical row count |
| shape_err | output | 1 | Last shape write was illegal |
| start | input | 1 | Begin a tile |
| tile_mt | input | MTW (6) | Reduction depth Mt of the tile |
| op_take | output | 1 | Operand vectors are captured this cycle |
| a_in | input | LMAX·DW (224) | A column vector, one lane per logical row |
| b_in | input | LMAX·DW (224) | B row vector, one lane per logical column |
| done | output | 1 | Tile execution time reached |
| res_valid | output | 1 | res_row holds a result row |
| res_row_idx | output | RW (5) | Index of the row on res_row |
| res_row | output | LMAX·AW (616) | Result row, one lane per logical column |

## Verification
The bench goes after the columns and rows that lie just past a quarter turn in both flattened orientations. A design that skipped the bypass stage, or skewed the other operand wrongly, would pair A and B terms from different k there and give wrong sums only beyond the turn. It checks the done cycle against the Texe formula for the square shape, the 1×28 chain, the 28×1 chain and intermediate shapes. An off-by-one in the turn term or the load phase would show up as a shifted pulse. It drives illegal and mid-run shape writes, then runs a tile and counts result rows and lanes. A design that let such a write through would return the wrong row count or extra lanes. Junk on unused lanes and outside the capture window is left on the inputs throughout, so a leaky capture corrupts the sums. One all-255 run at the deepest Mt exposes a narrow accumulator.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
   typedef enum logic [1:0] {
      SHP_SQUARE,
      SHP_ROWFLAT,
      SHP_COLFLAT
   } shape_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RUN,
      ST_OUT
   } run_state_e;
endpackage

// File: rtl/rsa_shape_reg.sv
module rsa_shape_reg
   import rsa_pkg::*;
#(
   parameter int P    = 8,
   parameter int LMAX = 4 * (P - 1),
   parameter int RW   = 5,
   parameter int SW   = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [RW-1:0]              req_rows,
   output logic [RW-1:0]              rl_o,
   output logic [RW-1:0]              cl_o,
   output shape_mode_e                mode_o,
   output logic                       err_o,
   output logic [LMAX-1:0]            row_turn_o,
   output logic [LMAX-1:0]            col_turn_o,
   output logic [LMAX-1:0][SW-1:0]    row_dly_o,
   output logic [LMAX-1:0][SW-1:0]    col_dly_o
);
   logic        legal;
   int          n_cl;
   shape_mode_e n_mode;

   // legality of the requested row count and derived column count
   always_comb begin
      int req;
      req    = int'(req_rows);
      legal  = 1'b0;
      n_cl   = P;
      n_mode = SHP_SQUARE;
      if (req == P) begin
         legal = 1'b1;
      end else if (req >= 1 && req <= P / 2) begin
         legal  = 1'b1;
         n_cl   = 4 * (P - req);
         n_mode = SHP_ROWFLAT;
      end else if (req % 4 == 0 && req / 4 >= P - P / 2 && req / 4 <= P - 1) begin
         legal  = 1'b1;
         n_cl   = P - req / 4;
         n_mode = SHP_COLFLAT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rl_o   <= RW'(P);
         cl_o   <= RW'(P);
         mode_o <= SHP_SQUARE;
         err_o  <= 1'b0;
      end else if (wr_en) begin
         if (legal) begin
            rl_o   <= req_rows;
            cl_o   <= RW'(n_cl);
            mode_o <= n_mode;
            err_o  <= 1'b0;
         end else begin
            err_o  <= 1'b1;
         end
      end
   end

   // quarter turns: one bypass stage at the head of each later quarter
   always_comb begin
      int seg_c, seg_r, pos, nt;
      seg_c = P - int'(rl_o);
      seg_r = P - int'(cl_o);
      pos = 0;
      nt  = 0;
      for (int c = 0; c < LMAX; c++) begin
         col_turn_o[c] = 1'b0;
         if (mode_o == SHP_ROWFLAT && c != 0 && pos == seg_c) begin
            col_turn_o[c] = 1'b1;
            nt  = nt + 1;
            pos = 0;
         end
         pos          = pos + 1;
         col_dly_o[c] = SW'(c + nt);
      end
      pos = 0;
      nt  = 0;
      for (int r = 0; r < LMAX; r++) begin
         row_turn_o[r] = 1'b0;
         if (mode_o == SHP_COLFLAT && r != 0 && pos == seg_r) begin
            row_turn_o[r] = 1'b1;
            nt  = nt + 1;
            pos = 0;
         end
         pos          = pos + 1;
         row_dly_o[r] = SW'(r + nt);
      end
   end
endmodule

// File: rtl/rsa_skew.sv
module rsa_skew #(
   parameter int LANES = 28,
   parameter int DW    = 8,
   parameter int SW    = 5,
   localparam int DEPTH = 1 << SW
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        take,
   input  logic [LANES*DW-1:0]         bus,
   input  logic [LANES-1:0][SW-1:0]    dly,
   output logic [LANES-1:0][DW-1:0]    q
);
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [DW-1:0] sh [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int j = 0; j < DEPTH; j++) sh[j] <= '0;
         end else if (clr) begin
            for (int j = 0; j < DEPTH; j++) sh[j] <= '0;
         end else begin
            sh[0] <= take ? bus[l*DW +: DW] : '0;
            for (int j = 1; j < DEPTH; j++) sh[j] <= sh[j-1];
         end
      end

      assign q[l] = sh[dly[l]];
   end
endmodule

// File: rtl/rsa_pe_grid.sv
module rsa_pe_grid #(
   parameter int P    = 8,
   parameter int DW   = 8,
   parameter int AW   = 22,
   parameter int LMAX = 4 * (P - 1),
   parameter int RW   = 5,
   localparam int NPE = P * P
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       en,
   input  logic [RW-1:0]              cl,
   input  logic [LMAX-1:0]            row_turn,
   input  logic [LMAX-1:0]            col_turn,
   input  logic [LMAX-1:0][DW-1:0]    a_sk,
   input  logic [LMAX-1:0][DW-1:0]    b_sk,
   output logic [NPE-1:0][AW-1:0]     acc_o
);
   logic [NPE-1:0][DW-1:0] a_all, b_all;
   int pe_r [NPE];
   int pe_c [NPE];

   // logical (row, column) of each element, row-major over the active shape
   always_comb begin
      int r, c;
      r = 0;
      c = 0;
      for (int i = 0; i < NPE; i++) begin
         pe_r[i] = r;
         pe_c[i] = c;
         c = c + 1;
         if (c == int'(cl)) begin
            c = 0;
            r = r + 1;
         end
      end
   end

   for (genvar i = 0; i < NPE; i++) begin : g_pe
      localparam int LI = (i > 0) ? i - 1 : 0;
      logic [DW-1:0]   a_q, b_q, a_byp, b_byp, a_inj, b_inj, a_left, b_up;
      logic            a_turn, b_turn;
      logic [AW-1:0]   acc_q;
      logic [2*DW-1:0] prod;

      assign a_left = (i == 0) ? '0 : a_all[LI];
      assign prod   = a_q * b_q;

      always_comb begin
         a_inj  = '0;
         b_inj  = '0;
         a_turn = 1'b0;
         b_turn = 1'b0;
         b_up   = '0;
         for (int l = 0; l < LMAX; l++) begin
            if (pe_r[i] == l) begin
               a_inj  = a_sk[l];
               b_turn = row_turn[l];
            end
            if (pe_c[i] == l) begin
               b_inj  = b_sk[l];
               a_turn = col_turn[l];
            end
         end
         for (int j = 0; j < i; j++) begin
            if (j == i - int'(cl)) b_up = b_all[j];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q <= '0; b_q <= '0; a_byp <= '0; b_byp <= '0; acc_q <= '0;
         end else if (clr) begin
            a_q <= '0; b_q <= '0; a_byp <= '0; b_byp <= '0; acc_q <= '0;
         end else begin
            a_byp <= a_left;
            b_byp <= b_up;
            a_q   <= (pe_c[i] == 0) ? a_inj : (a_turn ? a_byp : a_left);
            b_q   <= (pe_r[i] == 0) ? b_inj : (b_turn ? b_byp : b_up);
            if (en) acc_q <= acc_q + AW'(prod);
         end
      end

      assign a_all[i] = a_q;
      assign b_all[i] = b_q;
      assign acc_o[i] = acc_q;
   end
endmodule

// File: rtl/ring_systolic_array.sv
module ring_systolic_array
   import rsa_pkg::*;
#(
   parameter int P   = 8,
   parameter int DW  = 8,
   parameter int MTW = 6,
   localparam int LMAX  = 4 * (P - 1),
   localparam int RW    = $clog2(LMAX + 1),
   localparam int SW    = $clog2(LMAX + 3),
   localparam int AW    = 2 * DW + MTW,
   localparam int NPE   = P * P,
   localparam int MTMAX = (1 << MTW) - 1,
   localparam int CW    = $clog2(3 * LMAX + MTMAX + 4 * P + 2)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [RW-1:0]        cfg_rows,
   output logic                 shape_err,
   input  logic                 start,
   input  logic [MTW-1:0]       tile_mt,
   output logic                 op_take,
   input  logic [LMAX*DW-1:0]   a_in,
   input  logic [LMAX*DW-1:0]   b_in,
   output logic                 done,
   output logic                 res_valid,
   output logic [RW-1:0]        res_row_idx,
   output logic [LMAX*AW-1:0]   res_row
);
   if (P < 4 || P % 2 != 0) begin : g_bad_side
      $error("grid side must be even and at least 4");
   end
   if (DW < 1 || MTW < 1) begin : g_bad_width
      $error("operand and depth widths must be positive");
   end

   run_state_e                st;
   logic [CW-1:0]             cnt;
   logic [MTW-1:0]            mt_q;
   logic [RW-1:0]             orow, rl, cl;
   shape_mode_e               mode;
   logic [LMAX-1:0]           row_turn, col_turn;
   logic [LMAX-1:0][SW-1:0]   row_dly, col_dly;
   logic [LMAX-1:0][DW-1:0]   a_sk, b_sk;
   logic [NPE-1:0][AW-1:0]    acc;
   logic                      idle, clr, run;
   int                        texe;

   assign idle = (st == ST_IDLE);
   assign run  = (st == ST_RUN);
   assign clr  = idle && start;

   rsa_shape_reg #(.P(P), .LMAX(LMAX), .RW(RW), .SW(SW)) u_shape (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr && idle), .req_rows(cfg_rows),
      .rl_o(rl), .cl_o(cl), .mode_o(mode), .err_o(shape_err),
      .row_turn_o(row_turn), .col_turn_o(col_turn),
      .row_dly_o(row_dly), .col_dly_o(col_dly)
   );

   rsa_skew #(.LANES(LMAX), .DW(DW), .SW(SW)) u_skew_a (
      .clk(clk), .rst_n(rst_n), .clr(clr), .take(op_take),
      .bus(a_in), .dly(row_dly), .q(a_sk)
   );

   rsa_skew #(.LANES(LMAX), .DW(DW), .SW(SW)) u_skew_b (
      .clk(clk), .rst_n(rst_n), .clr(clr), .take(op_take),
      .bus(b_in), .dly(col_dly), .q(b_sk)
   );

   rsa_pe_grid #(.P(P), .DW(DW), .AW(AW), .LMAX(LMAX), .RW(RW)) u_grid (
      .clk(clk), .rst_n(rst_n), .clr(clr), .en(run), .cl(cl),
      .row_turn(row_turn), .col_turn(col_turn),
      .a_sk(a_sk), .b_sk(b_sk), .acc_o(acc)
   );

   // execution time: load phase, stream and skew, turn bypass allowance
   always_comb begin
      int m;
      m    = (rl < cl) ? int'(rl) : int'(cl);
      texe = 2 * int'(rl) + int'(cl) + int'(mt_q) - 1 + 4 * m;
   end

   assign op_take   = run && int'(cnt) >= int'(rl) && int'(cnt) < int'(rl) + int'(mt_q);
   assign done      = run && int'(cnt) == texe;
   assign res_valid = (st == ST_OUT);
   assign res_row_idx = orow;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cnt  <= '0;
         mt_q <= '0;
         orow <= '0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               st   <= ST_RUN;
               cnt  <= '0;
               mt_q <= tile_mt;
            end
            ST_RUN: begin
               cnt <= cnt + 1'b1;
               if (done) begin
                  st   <= ST_OUT;
                  orow <= '0;
               end
            end
            default: begin
               if (orow == rl - 1'b1) st <= ST_IDLE;
               else                   orow <= orow + 1'b1;
            end
         endcase
      end
   end

   always_comb begin
      res_row = '0;
      if (st == ST_OUT) begin
         for (int c = 0; c < LMAX; c++) begin
            if (c < int'(cl)) begin
               for (int i = 0; i < NPE; i++) begin
                  if (i == int'(orow) * int'(cl) + c) res_row[c*AW +: AW] = acc[i];
               end
            end
         end
      end
   end
endmodule

// File: rtl/rsa_checker.sv
module rsa_checker #(
   parameter int RW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_wr,
   input logic          idle,
   input logic          op_take,
   input logic          done,
   input logic          res_valid,
   input logic          shape_err,
   input logic [RW-1:0] res_row_idx,
   input logic [RW-1:0] rl
);
   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   rows_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (res_valid && res_row_idx == '0));

   // R9
   rows_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_row_idx != rl - 1'b1) |=>
         (res_valid && res_row_idx == $past(res_row_idx) + 1'b1));

   // R4
   take_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_take |-> (!done && !res_valid));

   // R3
   busy_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && !idle) |=> ($stable(rl) && $stable(shape_err)));

   // R2
   reject_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shape_err) |-> $stable(rl));
endmodule

bind ring_systolic_array rsa_checker #(.RW(RW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .idle(st == ST_IDLE),
   .op_take(op_take), .done(done), .res_valid(res_valid),
   .shape_err(shape_err), .res_row_idx(res_row_idx), .rl(rl)
);

// File: tb/ring_systolic_array_test.sv
module ring_systolic_array_test;
   localparam int P    = 8;
   localparam int DW   = 8;
   localparam int MTW  = 6;
   localparam int LMAX = 4 * (P - 1);
   localparam int RW   = $clog2(LMAX + 1);
   localparam int AW   = 2 * DW + MTW;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                cfg_wr = 1'b0;
   logic [RW-1:0]       cfg_rows = '0;
   logic                shape_err;
   logic                start = 1'b0;
   logic [MTW-1:0]      tile_mt = '0;
   logic                op_take;
   logic [LMAX*DW-1:0]  a_in = '1;
   logic [LMAX*DW-1:0]  b_in = '1;
   logic                done;
   logic                res_valid;
   logic [RW-1:0]       res_row_idx;
   logic [LMAX*AW-1:0]  res_row;

   int total = 0;
   int bad   = 0;
   int am [LMAX][64];
   int bm [64][LMAX];

   ring_systolic_array #(.P(P), .DW(DW), .MTW(MTW)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rows(cfg_rows),
      .shape_err(shape_err), .start(start), .tile_mt(tile_mt),
      .op_take(op_take), .a_in(a_in), .b_in(b_in), .done(done),
      .res_valid(res_valid), .res_row_idx(res_row_idx), .res_row(res_row)
   );

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   task automatic set_shape(input int v, input bit exp_err, input string req);
      @(negedge clk);
      cfg_wr   = 1'b1;
      cfg_rows = RW'(v);
      @(negedge clk);
      cfg_wr   = 1'b0;
      chk(shape_err == exp_err, req, longint'(shape_err), longint'(exp_err));
   endtask

   // one tile: feeds A and B, checks take window, done cycle and every result row
   task automatic run_tile(input int rl, input int cl, input int mt, input int seed,
                           input bit disturb, input string req);
      int k, cyc, first_take, done_cyc, rows, texe, m, row_bad;
      for (int r = 0; r < LMAX; r++)
         for (int kk = 0; kk < 64; kk++)
            am[r][kk] = (seed < 0) ? 255 : (r * 7 + kk * 13 + seed * 5 + 1) % 256;
      for (int kk = 0; kk < 64; kk++)
         for (int c = 0; c < LMAX; c++)
            bm[kk][c] = (seed < 0) ? 255 : (c * 11 + kk * 3 + seed * 9 + 2) % 256;
      m    = (rl < cl) ? rl : cl;
      texe = 2 * rl + cl + mt - 1 + 4 * m;
      @(negedge clk);
      start   = 1'b1;
      tile_mt = MTW'(mt);
      @(negedge clk);
      start = 1'b0;
      cyc = 1; k = 0; first_take = -1; done_cyc = -1;
      while (done_cyc < 0 && cyc < 1000) begin
         cfg_wr = 1'b0;
         start  = 1'b0;
         a_in   = '1;
         b_in   = '1;
         if (op_take) begin
            if (first_take < 0) first_take = cyc;
            for (int r = 0; r < LMAX; r++)
               a_in[r*DW +: DW] = (r < rl) ? DW'(am[r][k]) : DW'(8'hA5);
            for (int c = 0; c < LMAX; c++)
               b_in[c*DW +: DW] = (c < cl) ? DW'(bm[k][c]) : DW'(8'h5A);
            k++;
         end
         if (done) done_cyc = cyc;
         if (disturb && cyc == 3) begin
            cfg_wr   = 1'b1;
            cfg_rows = RW'(P);
            start    = 1'b1;
         end
         @(negedge clk);
         cyc++;
      end
      cfg_wr = 1'b0;
      start  = 1'b0;
      chk(first_take == rl + 1, "R4 first take", first_take, rl + 1);
      chk(k == mt, "R4 take count", k, mt);
      chk(done_cyc == texe + 1, "R5 done cycle", done_cyc, texe + 1);
      rows = 0;
      while (res_valid && rows < 64) begin
         row_bad = 0;
         chk(int'(res_row_idx) == rows, "R9 row index", res_row_idx, rows);
         for (int c = 0; c < LMAX; c++) begin
            longint exp, act;
            exp = 0;
            if (c < cl)
               for (int kk = 0; kk < mt; kk++) exp += longint'(am[rows][kk]) * longint'(bm[kk][c]);
            act = longint'(res_row[c*AW +: AW]);
            if (act != exp && row_bad == 0) begin
               row_bad = 1;
               chk(1'b0, req, act, exp);
            end
         end
         if (row_bad == 0) chk(1'b1, req, 0, 0);
         rows++;
         @(negedge clk);
      end
      chk(rows == rl, "R9 row count", rows, rl);
   endtask

   task automatic t_reset();
      chk(shape_err == 1'b0, "R1 reset err", shape_err, 0);
      chk(done == 1'b0 && res_valid == 1'b0, "R1 reset idle", {done, res_valid}, 0);
      chk(op_take == 1'b0, "R4 reset take", op_take, 0);
      run_tile(8, 8, 5, 1, 1'b0, "R1 default square");
   endtask

   task automatic t_square();
      set_shape(8, 1'b0, "R1 square write");
      run_tile(8, 8, 7, 2, 1'b0, "R6/R10 square product");
      run_tile(8, 8, 63, -1, 1'b0, "R6 max depth all 255");
   endtask

   task automatic t_rowflat();
      set_shape(1, 1'b0, "R1 chain write");
      run_tile(1, 28, 9, 3, 1'b0, "R7/R10 chain product");
      set_shape(3, 1'b0, "R1 row flat write");
      run_tile(3, 20, 4, 4, 1'b0, "R7 row flat product");
   endtask

   task automatic t_colflat();
      set_shape(28, 1'b0, "R1 column chain write");
      run_tile(28, 1, 5, 5, 1'b0, "R8/R10 column chain product");
      set_shape(20, 1'b0, "R1 column flat write");
      run_tile(20, 3, 6, 6, 1'b0, "R8 column flat product");
   endtask

   task automatic t_illegal();
      set_shape(5, 1'b1, "R2 reject 5");
      run_tile(20, 3, 3, 7, 1'b0, "R2 shape kept after reject");
      set_shape(0, 1'b1, "R2 reject 0");
      set_shape(29, 1'b1, "R2 reject 29");
      set_shape(4, 1'b0, "R2 legal write clears err");
      run_tile(4, 16, 4, 8, 1'b0, "R1/R7 quarter shape product");
   endtask

   task automatic t_busy();
      run_tile(4, 16, 6, 9, 1'b1, "R3 run with busy writes");
      chk(shape_err == 1'b0, "R3 err untouched", shape_err, 0);
      run_tile(4, 16, 2, 10, 1'b0, "R3 shape kept after busy write");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_square();
      t_rowflat();
      t_colflat();
      t_illegal();
      t_busy();
      report();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      report();
      $finish;
   end
endmodule